// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes one or more SDRAM devices from power-on to a state where normal traffic may begin. After a start request it holds clock enable low for a programmable stabilization time. It then raises clock enable and drives NOP for a second programmable time. Next it closes every bank with one precharge-all, then issues eight auto-refresh commands at the fastest rate of one per 16 clocks. It programs the device mode register, waits the mode-register recovery time, and raises a sticky done flag.

The mode word goes out on the row address lines and the bank address lines stay at zero. The word selects a burst of eight with sequential ordering and standard operation, and writes use the programmed burst length. The CAS latency field is taken from an input that is set to suit the SDRAM clock frequency. Every output is registered. Each state shows at the pins one clock after the machine enters it.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, and for as long as no start arrives, cke_o is low, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), row_o is zero and done_o is low. A reset given mid-sequence restores this state.
- R2: For the first PWRUP_CYC clocks after the edge that samples start_i, cke_o stays low and the command is NOP.
- R3: For the next NOP_CYC clocks, cke_o is high and the command is NOP. cke_o then stays high.
- R4: In the following clock one PRECHARGE command (0010) is driven with row_o bit 10 high, all other row bits zero, and ba_o zero.
- R5: Starting in the clock after the precharge, exactly eight AUTO REFRESH commands (0001) are driven 16 clocks apart. Every other clock in that 128-clock window is NOP.
- R6: In the clock after the refresh window one MODE REGISTER SET (0000) is driven with ba_o zero. row_o carries bits [2:0]=011 (burst 8), bit 3=0 (sequential), bits [6:4]=cas_lat_i, bits [8:7]=00 (standard operation), bit 9=0 (writes use the burst length), and all higher bits zero.
- R7: After the mode set, TMRD_CYC NOP clocks pass with done_o low. done_o then goes high and stays high until reset, with the command held at NOP.
- R8: A start_i pulse while the sequence is running, or after done_o is high, has no effect on the command timeline or on done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin initialization |
| cas_lat_i | input | 3 | CAS latency code placed in the mode word |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| row_o | output | ROW_W | Row address lines |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
The bench follows the whole command timeline clock by clock from the start edge and checks the phase boundaries. An off-by-one wait counter would move the rise of clock enable or the precharge by a cycle. A refresh counter that wraps wrongly would give seven or nine refreshes, or spacing other than 16. The bench counts every refresh and checks the first and last one. It checks the mode word with two CAS latency values, so a field placed in the wrong bits or a latency captured at the wrong time is caught. It also sends start pulses mid-run and after completion, and applies a reset while clock enable is already high, so that a machine that restarts or drops done would be seen.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PWR,
    S_NOPW,
    S_PRE,
    S_REF,
    S_MRS,
    S_MRD,
    S_DONE
  } init_state_t;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_modeword.sv
module sdram_init_modeword #(
  parameter int ROW_W = 13
) (
  input  logic [2:0]       cas_lat_i,
  output logic [ROW_W-1:0] mode_o
);

  always_comb begin
    mode_o      = '0;
    mode_o[2:0] = 3'b011;     // burst of eight
    mode_o[3]   = 1'b0;       // sequential ordering
    mode_o[6:4] = cas_lat_i;  // CAS latency
    mode_o[8:7] = 2'b00;      // standard operation
    mode_o[9]   = 1'b0;       // writes follow burst length
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int NOP_CYC   = 40000,
  parameter int TMRD_CYC  = 2,
  parameter int REF_INT   = 16,
  parameter int REF_NUM   = 8,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       cas_lat_i,
  output logic             cke_o,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] row_o,
  output logic             done_o
);

  localparam int MAX_A    = (PWRUP_CYC > NOP_CYC) ? PWRUP_CYC : NOP_CYC;
  localparam int MAX_WAIT = (MAX_A > TMRD_CYC) ? MAX_A : TMRD_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int SUB_W    = (REF_INT > 1) ? $clog2(REF_INT) : 1;
  localparam int RN_W     = (REF_NUM > 1) ? $clog2(REF_NUM) : 1;

  init_state_t      state_q, state_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             cnt_zero;
  logic [SUB_W-1:0] sub_q;
  logic [RN_W-1:0]  refn_q;
  logic             slot_last, ref_last;
  logic [ROW_W-1:0] mode_word;

  sd_cmd_t          cmd_d, cmd_q;
  logic [ROW_W-1:0] row_d;
  logic             cke_d, done_d;

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (cnt_zero)
  );

  sdram_init_modeword #(.ROW_W(ROW_W)) u_mode (
    .cas_lat_i (cas_lat_i),
    .mode_o    (mode_word)
  );

  assign slot_last = (sub_q == SUB_W'(REF_INT - 1));
  assign ref_last  = (refn_q == RN_W'(REF_NUM - 1));

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_PWR;
        ld      = 1'b1;
        ld_val  = CNT_W'(PWRUP_CYC - 1);
      end
      S_PWR: if (cnt_zero) begin
        state_d = S_NOPW;
        ld      = 1'b1;
        ld_val  = CNT_W'(NOP_CYC - 1);
      end
      S_NOPW: if (cnt_zero) state_d = S_PRE;
      S_PRE:  state_d = S_REF;
      S_REF:  if (slot_last && ref_last) state_d = S_MRS;
      S_MRS: begin
        state_d = S_MRD;
        ld      = 1'b1;
        ld_val  = CNT_W'(TMRD_CYC - 1);
      end
      S_MRD:  if (cnt_zero) state_d = S_DONE;
      S_DONE: state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst || state_q != S_REF) begin
      sub_q  <= '0;
      refn_q <= '0;
    end else begin
      sub_q <= slot_last ? '0 : sub_q + 1'b1;
      if (slot_last) refn_q <= refn_q + 1'b1;
    end
  end

  always_comb begin
    cmd_d  = CMD_NOP;
    row_d  = '0;
    cke_d  = !(state_q == S_IDLE || state_q == S_PWR);
    done_d = (state_q == S_DONE);
    case (state_q)
      S_PRE: begin
        cmd_d     = CMD_PRE;
        row_d[10] = 1'b1;
      end
      S_REF: if (sub_q == '0) cmd_d = CMD_REF;
      S_MRS: begin
        cmd_d = CMD_MRS;
        row_d = mode_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      row_o  <= '0;
      ba_o   <= '0;
      cke_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      row_o  <= row_d;
      ba_o   <= '0;
      cke_o  <= cke_d;
      done_o <= done_d;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

  // Spacing monitor for refresh commands at the pins
  logic [7:0] gap_q;
  logic       ref_seen_q;
  logic       ref_out;
  assign ref_out = (cmd_q == CMD_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= '0;
      ref_seen_q <= 1'b0;
    end else if (ref_out) begin
      gap_q      <= '0;
      ref_seen_q <= 1'b1;
    end else if (gap_q != 8'hff) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> cke_o) else $error("command with cke low"); // R2

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (row_o[10] && ba_o == '0)) else $error("precharge not all banks"); // R4

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (ref_out && ref_seen_q) |-> (gap_q == 8'(REF_INT - 1))) else $error("refresh spacing"); // R5

  AST_MRS_CAS_FIELD: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (row_o[6:4] == $past(cas_lat_i) && row_o[2:0] == 3'b011)) else $error("mode word"); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && cmd_q == CMD_NOP)) else $error("done dropped"); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && start_i) |=> (state_q != S_IDLE)) else $error("restart while busy"); // R8

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int P = 20;
  localparam int N = 10;
  localparam int M = 2;
  localparam int ROW_W = 13;
  localparam int BA_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] cas_lat_i = 3'd3;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [BA_W-1:0] ba_o;
  logic [ROW_W-1:0] row_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(P), .NOP_CYC(N), .TMRD_CYC(M),
    .REF_INT(16), .REF_NUM(8), .ROW_W(ROW_W), .BA_W(BA_W)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cas_lat_i(cas_lat_i),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ba_o(ba_o), .row_o(row_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [15:0] k;
    logic [3:0]  req;
    logic        cke;
    logic [3:0]  cmd;
    logic [12:0] row;
    logic        done;
  } vec_t;

  // k counts clock edges after the edge that samples start
  localparam vec_t VEC [16] = '{
    '{16'd1,   4'd2, 1'b0, 4'b0111, 13'h000, 1'b0},  // R2 wait start
    '{16'd20,  4'd2, 1'b0, 4'b0111, 13'h000, 1'b0},  // R2 wait end
    '{16'd21,  4'd3, 1'b1, 4'b0111, 13'h000, 1'b0},  // R3 cke rises
    '{16'd30,  4'd3, 1'b1, 4'b0111, 13'h000, 1'b0},  // R3 last NOP
    '{16'd31,  4'd4, 1'b1, 4'b0010, 13'h400, 1'b0},  // R4 precharge all
    '{16'd32,  4'd5, 1'b1, 4'b0001, 13'h000, 1'b0},  // R5 first refresh
    '{16'd33,  4'd5, 1'b1, 4'b0111, 13'h000, 1'b0},  // R5 gap
    '{16'd47,  4'd5, 1'b1, 4'b0111, 13'h000, 1'b0},  // R5 gap end
    '{16'd48,  4'd5, 1'b1, 4'b0001, 13'h000, 1'b0},  // R5 second refresh
    '{16'd144, 4'd5, 1'b1, 4'b0001, 13'h000, 1'b0},  // R5 eighth refresh
    '{16'd145, 4'd5, 1'b1, 4'b0111, 13'h000, 1'b0},  // R5 after last
    '{16'd159, 4'd5, 1'b1, 4'b0111, 13'h000, 1'b0},  // R5 window end
    '{16'd160, 4'd6, 1'b1, 4'b0000, 13'h033, 1'b0},  // R6 mode set CL3
    '{16'd161, 4'd7, 1'b1, 4'b0111, 13'h000, 1'b0},  // R7 tMRD
    '{16'd162, 4'd7, 1'b1, 4'b0111, 13'h000, 1'b0},  // R7 tMRD
    '{16'd163, 4'd7, 1'b1, 4'b0111, 13'h000, 1'b1}   // R7 done
  };

  function automatic logic [3:0] cmd_now();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int refs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "cke", cke_o, 0);
    check("R1", "cmd", cmd_now(), 4'b0111);
    check("R1", "done", done_o, 0);
    repeat (10) @(negedge clk);
    check("R1", "idle cke", cke_o, 0);

    // Table walk, CAS latency 3, with a stray start at k=50 (R8)
    refs = 0;
    pulse_start();
    for (int k = 1; k <= 170; k++) begin
      if (k == 50) start_i = 1'b1;
      if (k == 51) start_i = 1'b0;
      @(negedge clk);
      if (cmd_now() == 4'b0001) refs++;
      for (int i = 0; i < 16; i++) begin
        if (VEC[i].k == 16'(k)) begin
          string r;
          r = $sformatf("R%0d", VEC[i].req);
          check(r, "cke", cke_o, VEC[i].cke);
          check(r, "cmd", cmd_now(), VEC[i].cmd);
          check(r, "row", row_o, VEC[i].row);
          check(r, "ba", ba_o, 0);
          check(r, "done", done_o, VEC[i].done);
        end
      end
    end
    check("R5", "refresh count", refs, 8);

    // R8 start after done
    pulse_start();
    repeat (5) @(negedge clk);
    check("R8", "done held", done_o, 1);
    check("R8", "cmd after done", cmd_now(), 4'b0111);

    // R1 reset mid-sequence while cke is high
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    pulse_start();
    repeat (25) @(negedge clk);
    check("R3", "cke mid", cke_o, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "cke after reset", cke_o, 0);
    check("R1", "done after reset", done_o, 0);
    repeat (8) @(negedge clk);
    check("R1", "stays idle", cmd_now(), 4'b0111);

    // R6 second CAS latency
    cas_lat_i = 3'd2;
    pulse_start();
    for (int k = 1; k <= 163; k++) begin
      @(negedge clk);
      if (k == 160) begin
        check("R6", "mode cmd CL2", cmd_now(), 4'b0000);
        check("R6", "mode row CL2", row_o, 13'h023);
        check("R6", "mode ba", ba_o, 0);
      end
      if (k == 163) check("R7", "done CL2", done_o, 1);
    end
    finish_run();
  end

endmodule